// File: doc/BRIEF.md
# CAS Signaling Change Notifier

This block holds the robbed-bit signaling of 24 T1 channels in a bank of twelve 8-bit receive signaling registers. Each register carries two channels. The bit extractor that reads the line writes the registers while a multiframe is in progress, and those writes collect in a staging copy. On each multiframe strobe the staging copy is compared with the values committed at the previous strobe, and then it becomes the new committed set.

When a channel that is not excluded has changed, the block raises a sticky interrupt. It also presents a pointer to the lowest-numbered register that changed, and a flag that shows whether more than one register changed. With this the host reads only the register that was updated and does not have to poll all twelve every 3 ms.

A per-time-slot clear-channel mask serves two purposes. When the suppress control is set, masked channels are left out of change detection. Independently of that control, the mask also takes away the signaling-insertion enable for each masked time slot.

Top module: `cas_chg_notify`

## Requirements
- R1: A synchronous reset clears irq, multi_chg, chg_ptr and every staged and committed register to zero.
- R2: A write with an index from 0 to 11 goes to staging and becomes visible at rd_data only after the next multiframe strobe. A write in the same cycle as the strobe belongs to the following multiframe, and a write with an index of 12 or above is ignored. rd_data shows the committed register selected by rd_idx one cycle later, and 0 for an index of 12 or above.
- R3: The first multiframe strobe after reset only sets the baseline and never raises irq.
- R4: From the second strobe on, irq is 1 in the cycle after a strobe at which any channel that is not excluded differs between staging and committed. If no such channel differs, that strobe does not set irq.
- R5: Register k holds channel 2k in bits [3:0] and channel 2k+1 in bits [7:4]. On a change, chg_ptr gives the 0-based index of the lowest-numbered register with a change that is not excluded.
- R6: On a change, multi_chg is 1 when two or more registers changed at that strobe and 0 when only one did.
- R7: irq and multi_chg stay set until stat_rd is pulsed, and stat_rd clears both. A strobe with no change leaves irq, chg_ptr and multi_chg as they are. When a change strobe and stat_rd arrive in the same cycle, the set takes priority.
- R8: When sup_en is 1, a channel c whose clr_mask[c] is 1 is excluded from change detection. When sup_en is 0, clr_mask has no effect on detection.
- R9: tx_ins_en[c] equals the inverse of clr_mask[c], registered with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mf_strobe | input | 1 | Multiframe boundary pulse |
| wr_en | input | 1 | Staging write enable from the bit extractor |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | 8 | Signaling for two channels |
| rd_idx | input | 4 | Host read index |
| rd_data | output | 8 | Committed register value, one cycle latency |
| stat_rd | input | 1 | Host status read, clears irq and multi_chg |
| sup_en | input | 1 | Exclude clear channels from change detection |
| clr_mask | input | 24 | Clear-channel mask, one bit per time slot |
| tx_ins_en | output | 24 | Signaling-insertion enable per time slot |
| irq | output | 1 | Sticky change interrupt |
| chg_ptr | output | 4 | Lowest-numbered changed register |
| multi_chg | output | 1 | More than one register changed |

## Verification
Detection is exercised with four kinds of update:
- A single-register update checks the pointer.
- A two-register update, with the higher index written first, shows that the pointer follows register order and not write order, and that the multi flag is set.
- A rewrite with an identical value, and a multiframe with no writes, must stay silent.
- Nibble-level edits under the mask, made with the suppress control both on and off, separate an excluded channel from its unmasked neighbour in the same register.

Directed cases cover the baseline strobe, stickiness, a clear that collides with a set, a write in the strobe cycle, out-of-range indices and a reset in the middle of a run.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int CH_W       = 4;
  localparam int CH_PER_REG = 2;

  typedef struct packed {
    logic       hit;
    logic       multi;
  } chg_flags_t;
endpackage

// File: rtl/cas_sig_store.sv
module cas_sig_store #(
  parameter int NUM_REG = 12,
  parameter int REG_W   = 8,
  parameter int IDX_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     commit,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [REG_W-1:0]         rd_data,
  output logic [NUM_REG*REG_W-1:0] staged_flat,
  output logic [NUM_REG*REG_W-1:0] held_flat
);
  logic [REG_W-1:0] stage_q [NUM_REG];
  logic [REG_W-1:0] held_q  [NUM_REG];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i] <= '0;
        held_q[i]  <= '0;
      end else begin
        if (wr_en && (int'(wr_idx) == i)) stage_q[i] <= wr_data;
        if (commit) held_q[i] <= stage_q[i];
      end
    end
    assign staged_flat[i*REG_W +: REG_W] = stage_q[i];
    assign held_flat[i*REG_W +: REG_W]   = held_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                        rd_data <= '0;
    else if (int'(rd_idx) < NUM_REG) rd_data <= held_q[rd_idx];
    else                            rd_data <= '0;
  end
endmodule

// File: rtl/cas_chg_detect.sv
module cas_chg_detect
  import cas_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int NUM_REG = NUM_CH / CH_PER_REG,
  parameter int REG_W   = CH_W * CH_PER_REG,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REG*REG_W-1:0] staged_flat,
  input  logic [NUM_REG*REG_W-1:0] held_flat,
  input  logic [NUM_CH-1:0]        excl,
  output chg_flags_t               flags,
  output logic [IDX_W-1:0]         low_idx
);
  logic [NUM_REG-1:0] reg_hit;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
    logic [CH_PER_REG-1:0] ch_hit;
    for (genvar c = 0; c < CH_PER_REG; c++) begin : g_ch
      localparam int CH = r * CH_PER_REG + c;
      localparam int LO = r * REG_W + c * CH_W;
      assign ch_hit[c] = (staged_flat[LO +: CH_W] != held_flat[LO +: CH_W]) && !excl[CH];
    end
    assign reg_hit[r] = |ch_hit;
  end

  always_comb begin
    int cnt;
    cnt     = 0;
    low_idx = '0;
    for (int r = NUM_REG - 1; r >= 0; r--) begin
      if (reg_hit[r]) begin
        low_idx = IDX_W'(r);
        cnt     = cnt + 1;
      end
    end
    flags.hit   = (cnt != 0);
    flags.multi = (cnt > 1);
  end
endmodule

// File: rtl/cas_ins_gate.sv
module cas_ins_gate #(
  parameter int NUM_CH = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] ins_en
);
  always_ff @(posedge clk) begin
    if (rst) ins_en <= '0;
    else     ins_en <= ~clr_mask;
  end
endmodule

// File: rtl/cas_chg_notify.sv
module cas_chg_notify
  import cas_pkg::*;
#(
  parameter int NUM_CH  = 24,
  localparam int NUM_REG = NUM_CH / CH_PER_REG,
  localparam int REG_W   = CH_W * CH_PER_REG,
  localparam int IDX_W   = $clog2(NUM_REG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mf_strobe,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rd_data,
  input  logic              stat_rd,
  input  logic              sup_en,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] tx_ins_en,
  output logic              irq,
  output logic [IDX_W-1:0]  chg_ptr,
  output logic              multi_chg
);
  logic [NUM_REG*REG_W-1:0] staged_flat;
  logic [NUM_REG*REG_W-1:0] held_flat;
  logic [NUM_CH-1:0]        excl;
  chg_flags_t               flags;
  logic [IDX_W-1:0]         low_idx;
  logic                     armed_q;

  assign excl = sup_en ? clr_mask : '0;

  cas_sig_store #(.NUM_REG(NUM_REG), .REG_W(REG_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit(mf_strobe), .rd_idx(rd_idx), .rd_data(rd_data),
    .staged_flat(staged_flat), .held_flat(held_flat)
  );

  cas_chg_detect #(.NUM_CH(NUM_CH), .NUM_REG(NUM_REG), .REG_W(REG_W), .IDX_W(IDX_W)) u_det (
    .staged_flat(staged_flat), .held_flat(held_flat), .excl(excl),
    .flags(flags), .low_idx(low_idx)
  );

  cas_ins_gate #(.NUM_CH(NUM_CH)) u_ins (
    .clk(clk), .rst(rst), .clr_mask(clr_mask), .ins_en(tx_ins_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      irq       <= 1'b0;
      chg_ptr   <= '0;
      multi_chg <= 1'b0;
    end else begin
      if (stat_rd) begin
        irq       <= 1'b0;
        multi_chg <= 1'b0;
      end
      if (mf_strobe) begin
        armed_q <= 1'b1;
        if (armed_q && flags.hit) begin
          irq       <= 1'b1;
          chg_ptr   <= low_idx;
          multi_chg <= flags.multi;
        end
      end
    end
  end
endmodule

// File: rtl/cas_chg_notify_chk.sv
module cas_chg_notify_chk #(
  parameter int NUM_CH  = 24,
  parameter int NUM_REG = 12,
  parameter int IDX_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mf_strobe,
  input logic              stat_rd,
  input logic [NUM_CH-1:0] clr_mask,
  input logic [NUM_CH-1:0] tx_ins_en,
  input logic              irq,
  input logic [IDX_W-1:0]  chg_ptr,
  input logic              multi_chg
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst)            seen_q <= 1'b0;
    else if (mf_strobe) seen_q <= 1'b1;
  end

  a_r3_baseline_quiet: assert property (@(posedge clk) disable iff (rst)
    (!seen_q && mf_strobe) |=> !irq);
  a_r4_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mf_strobe));
  a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    irq |-> (int'(chg_ptr) < NUM_REG));
  a_r6_multi_with_irq: assert property (@(posedge clk) disable iff (rst)
    multi_chg |-> irq);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !mf_strobe) |=> (!irq && !multi_chg));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_rd) |=> irq);
  a_r9_ins_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_ins_en == ~$past(clr_mask)));
endmodule

bind cas_chg_notify cas_chg_notify_chk #(.NUM_CH(NUM_CH), .NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mf_strobe(mf_strobe), .stat_rd(stat_rd), .clr_mask(clr_mask),
  .tx_ins_en(tx_ins_en), .irq(irq), .chg_ptr(chg_ptr), .multi_chg(multi_chg)
);

// File: tb/sim_cas_chg_notify.sv
module sim_cas_chg_notify;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mf_strobe = 1'b0, wr_en = 1'b0, stat_rd = 1'b0, sup_en = 1'b0;
  logic [3:0]  wr_idx = '0, rd_idx = '0, chg_ptr;
  logic [7:0]  wr_data = '0, rd_data;
  logic [23:0] clr_mask = '0, tx_ins_en;
  logic        irq, multi_chg;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cas_chg_notify u0 (.*);

  typedef struct packed {
    logic [3:0]  ia; logic [7:0] da; logic wa;
    logic [3:0]  ib; logic [7:0] db; logic wb;
    logic        sup; logic [23:0] mask;
    logic        e_irq; logic [3:0] e_ptr; logic e_multi;
  } vec_t;

  localparam vec_t TBL [0:8] = '{
    '{4'd5, 8'h12, 1'b1, 4'd0,  8'h00, 1'b0, 1'b0, 24'h0,      1'b1, 4'd5,  1'b0}, // R4 R5 single
    '{4'd9, 8'hA0, 1'b1, 4'd2,  8'h01, 1'b1, 1'b0, 24'h0,      1'b1, 4'd2,  1'b1}, // R5 R6 order
    '{4'd0, 8'h00, 1'b0, 4'd0,  8'h00, 1'b0, 1'b0, 24'h0,      1'b0, 4'd0,  1'b0}, // R4 idle
    '{4'd3, 8'h55, 1'b1, 4'd0,  8'h00, 1'b0, 1'b0, 24'h0,      1'b0, 4'd0,  1'b0}, // R4 same value
    '{4'd5, 8'h17, 1'b1, 4'd0,  8'h00, 1'b0, 1'b1, 24'h000400, 1'b0, 4'd0,  1'b0}, // R8 excluded
    '{4'd5, 8'h27, 1'b1, 4'd0,  8'h00, 1'b0, 1'b1, 24'h000400, 1'b1, 4'd5,  1'b0}, // R8 neighbour
    '{4'd5, 8'h28, 1'b1, 4'd0,  8'h00, 1'b0, 1'b0, 24'h000400, 1'b1, 4'd5,  1'b0}, // R8 sup off
    '{4'd0, 8'hFF, 1'b1, 4'd11, 8'h01, 1'b1, 1'b1, 24'h000003, 1'b1, 4'd11, 1'b0}, // R8 R6
    '{4'd11,8'h00, 1'b1, 4'd0,  8'h11, 1'b1, 1'b0, 24'h0,      1'b1, 4'd0,  1'b1}  // R5 R6
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic write_reg(input logic [3:0] idx, input logic [7:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mframe();
    mf_strobe = 1'b1;
    @(negedge clk);
    mf_strobe = 1'b0;
  endtask

  task automatic status_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [7:0] v);
    rd_idx = idx;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 0 && multi_chg == 0 && chg_ptr == 0, "R1 reset outputs", {irq, multi_chg, chg_ptr}, 0);
    read_reg(4'd3, v);
    chk(v == 8'h00, "R1 reset register", v, 0);

    write_reg(4'd3, 8'h55);
    read_reg(4'd3, v);
    chk(v == 8'h00, "R2 staged not visible", v, 0);
    mframe();
    chk(irq == 0, "R3 baseline strobe", irq, 0);
    read_reg(4'd3, v);
    chk(v == 8'h55, "R2 committed read", v, 8'h55);

    for (int i = 0; i < 9; i++) begin
      sup_en = TBL[i].sup; clr_mask = TBL[i].mask;
      if (TBL[i].wa) write_reg(TBL[i].ia, TBL[i].da);
      if (TBL[i].wb) write_reg(TBL[i].ib, TBL[i].db);
      mframe();
      chk(irq == TBL[i].e_irq, $sformatf("R4 R8 vector %0d irq", i), irq, TBL[i].e_irq);
      if (TBL[i].e_irq) begin
        chk(chg_ptr == TBL[i].e_ptr, $sformatf("R5 vector %0d ptr", i), chg_ptr, TBL[i].e_ptr);
        chk(multi_chg == TBL[i].e_multi, $sformatf("R6 vector %0d multi", i), multi_chg, TBL[i].e_multi);
      end
      status_read();
      chk(irq == 0 && multi_chg == 0, $sformatf("R7 vector %0d clear", i), {irq, multi_chg}, 0);
    end
    sup_en = 1'b0; clr_mask = '0;

    write_reg(4'd7, 8'h40);
    mframe();
    chk(irq == 1 && chg_ptr == 7, "R7 set", {irq, chg_ptr}, {1'b1, 4'd7});
    mframe();
    chk(irq == 1 && chg_ptr == 7, "R7 sticky over quiet strobe", {irq, chg_ptr}, {1'b1, 4'd7});
    status_read();
    chk(irq == 0, "R7 read clears", irq, 0);

    write_reg(4'd7, 8'h41);
    stat_rd = 1'b1; mf_strobe = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; mf_strobe = 1'b0;
    chk(irq == 1, "R7 set wins over clear", irq, 1);
    status_read();

    wr_en = 1'b1; wr_idx = 4'd4; wr_data = 8'h33; mf_strobe = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; mf_strobe = 1'b0;
    chk(irq == 0, "R2 write in strobe cycle deferred", irq, 0);
    mframe();
    chk(irq == 1 && chg_ptr == 4, "R2 deferred write detected", {irq, chg_ptr}, {1'b1, 4'd4});
    status_read();
    read_reg(4'd4, v);
    chk(v == 8'h33, "R2 deferred write committed", v, 8'h33);

    write_reg(4'd13, 8'hEE);
    mframe();
    chk(irq == 0, "R2 out-of-range write ignored", irq, 0);
    read_reg(4'd12, v);
    chk(v == 8'h00, "R2 out-of-range read", v, 0);

    clr_mask = 24'h800401;
    @(negedge clk);
    chk(tx_ins_en == 24'h7FFBFE, "R9 insertion enable", tx_ins_en, 24'h7FFBFE);
    clr_mask = '0;

    write_reg(4'd1, 8'h09);
    mframe();
    chk(irq == 1 && chg_ptr == 1, "R4 pre-reset change", {irq, chg_ptr}, {1'b1, 4'd1});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(irq == 0 && chg_ptr == 0 && multi_chg == 0, "R1 mid-run reset", {irq, chg_ptr, multi_chg}, 0);
    read_reg(4'd1, v);
    chk(v == 8'h00, "R1 mid-run reset register", v, 0);
    write_reg(4'd1, 8'h09);
    mframe();
    chk(irq == 0, "R3 baseline after reset", irq, 0);

    finish_run();
  end
endmodule